// File: doc/BRIEF.md
# Error-Correcting Word Store with Background Scrub

This block keeps a small array of 8-bit words, each stored next to four Hamming check bits and one overall parity bit, so 13 bits per location. A write encodes the data. A read decodes the stored word and returns the data one cycle later. Each read also returns a status: clean, corrected, or uncorrectable. A single flipped bit anywhere in the 13-bit word is repaired on the way out. Two flipped bits are reported and the data is passed through untouched, so the block never silently returns wrong data for them.

When the request port is idle, a scrub pointer reads one location per cycle. If that location holds a correctable error, the repaired 13-bit word is written back to it. Over time every word is revisited, so single upsets in rarely read words are cleaned before a second upset joins them. Requests always win over the scrubber, which picks up again at the same location. A fault-injection port XORs a mask into any stored word, so tests can create controlled upsets.

Top module: `secded_mem`

## Requirements
- R1: A word written and then read back with no upset returns the written data with status 2'b00 (clean). The stored layout is fixed: bits [7:0] hold data Z1..Z8 (bit 0 = Z1), bits [11:8] hold check bits c1..c4 and bit 12 holds parity. The check bits are c1 = Z1^Z2^Z4^Z5^Z7, c2 = Z1^Z3^Z4^Z6^Z7, c3 = Z2^Z3^Z4^Z8 and c4 = Z5^Z6^Z7^Z8. The parity bit makes the whole 13-bit word even.
- R2: `rsp_valid` is high exactly in the cycle after a read request (`req_valid`=1, `req_we`=0). `rsp_rdata` and `rsp_status` are valid in that cycle. A write request produces no response.
- R3: If one data bit of the stored word is flipped, the read returns the original data with status 2'b01 (corrected).
- R4: If one check bit or the parity bit alone is flipped, the read returns the data unchanged with status 2'b01.
- R5: If any two bits of the stored word are flipped, the read returns status 2'b10 (uncorrectable). The data returned is the stored data bits as they are, with no correction. Status 2'b11 never occurs.
- R6: If the syndrome is nonzero with odd overall parity but matches no column (syndrome 13, 14 or 15), the read returns status 2'b10 with the data unaltered.
- R7: In each cycle with no request and no injection, the scrubber reads the location at its pointer. If that word is correctable, it writes the repaired 13-bit word back. The pointer then advances by one, wrapping modulo the depth.
- R8: In any cycle with a request or an injection, the scrubber does nothing and its pointer holds. It resumes at that same location.
- R9: The scrubber never writes back a word classified as uncorrectable, so that word still reads as uncorrectable afterwards.
- R10: An injection (`inj_valid`=1) XORs `inj_mask` into the stored word at `inj_addr` at the clock edge, using the bit layout of R1. If a write request occurs in the same cycle, the injection is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request location |
| req_wdata | input | 8 | Data to write |
| rsp_valid | output | 1 | Read result valid |
| rsp_rdata | output | 8 | Read data, corrected when possible |
| rsp_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| inj_valid | input | 1 | Apply the upset mask this cycle |
| inj_addr | input | ADDR_W | Location to upset |
| inj_mask | input | 13 | Bits to flip in the stored word |

## Verification
The bench targets these corner cases:
- Every data value, read back clean.
- Every one of the 13 single-bit flips across several data patterns. A decoder that flipped the wrong column, or touched the data on a check-bit or parity flip, would return corrupted bytes under status 01.
- All 78 two-bit flips. A design that mistook an even-parity mismatch for a single error would miscorrect, and the bench sees a changed byte.
- Three multi-bit check-bit upsets that yield the unused syndromes 13, 14 and 15. These show whether a decoder wrongly calls them correctable.
- For the scrubber, the bench counts exactly how many words are repaired after one and two idle cycles. A pointer that moved during requests or injections, or skipped a location, changes that count or the repaired location.
- Finally, a two-bit upset must survive a full scrub pass unchanged.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int WW = DW + CW + 1;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FATAL = 2'b10
  } ecc_status_e;

  // check bits over data, d[0] is the first data bit
  function automatic logic [CW-1:0] hcheck(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c[0] = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c[1] = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c[2] = d[1] ^ d[2] ^ d[3] ^ d[7];
    c[3] = d[4] ^ d[5] ^ d[6] ^ d[7];
    return c;
  endfunction

  // syndrome produced by a flip of data bit idx: the idx-th value >= 3
  // that is not a power of two
  function automatic logic [CW-1:0] data_col(input int idx);
    int n;
    logic [CW-1:0] r;
    n = 0;
    r = '0;
    for (int v = 3; v < (1 << CW); v++) begin
      if ((v & (v - 1)) != 0) begin
        if (n == idx) r = CW'(v);
        n++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/secded_rst_sync.sv
module secded_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DW-1:0] data,
  output logic [WW-1:0] word
);
  logic [CW-1:0] chk;

  always_comb begin
    chk  = hcheck(data);
    word = {^{chk, data}, chk, data};
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [WW-1:0] word,
  output logic [DW-1:0] data,
  output logic [1:0]    status,
  output logic [WW-1:0] fixed
);
  logic [DW-1:0] raw;
  logic [CW-1:0] syn;
  logic          perr;
  logic [DW-1:0] hit;
  logic          chk_hit;
  ecc_status_e   st;

  assign raw  = word[DW-1:0];
  assign syn  = word[DW+CW-1:DW] ^ hcheck(raw);
  assign perr = ^word;

  for (genvar i = 0; i < DW; i++) begin : g_col
    assign hit[i] = (syn == data_col(i));
  end

  assign chk_hit = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

  always_comb begin
    data = raw;
    st   = ST_CLEAN;
    if (syn == '0) begin
      st = perr ? ST_FIXED : ST_CLEAN;
    end else if (!perr) begin
      st = ST_FATAL;
    end else if (|hit) begin
      data = raw ^ hit;
      st   = ST_FIXED;
    end else if (chk_hit) begin
      st = ST_FIXED;
    end else begin
      st = ST_FATAL;
    end
  end

  assign status = st;

  secded_enc u_reenc (
    .data (data),
    .word (fixed)
  );
endmodule

// File: rtl/secded_store.sv
module secded_store
  import secded_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WW-1:0]     wword,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WW-1:0]     rword,
  input  logic [ADDR_W-1:0] iaddr,
  output logic [WW-1:0]     iword
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wword;
  end

  assign rword = cells[raddr];
  assign iword = cells[iaddr];
endmodule

// File: rtl/secded_scrub.sv
module secded_scrub #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (step) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (step) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/secded_mem.sv
module secded_mem
  import secded_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata,
  output logic [1:0]        rsp_status,
  input  logic              inj_valid,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [12:0]       inj_mask
);
  logic              rst_core_n;
  logic [ADDR_W-1:0] scrub_ptr;
  logic              scrub_go;
  logic [ADDR_W-1:0] rd_addr;
  logic [WW-1:0]     rd_word, inj_word, enc_word, fix_word;
  logic [DW-1:0]     dec_data;
  logic [1:0]        dec_status;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WW-1:0]     wr_word;
  logic              is_read;
  logic              rsp_valid_q, rsp_valid_d;
  logic [DW-1:0]     rsp_data_q, rsp_data_d;
  logic [1:0]        rsp_stat_q, rsp_stat_d;

  secded_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign scrub_go = rst_core_n && !req_valid && !inj_valid;
  assign rd_addr  = req_valid ? req_addr : scrub_ptr;
  assign is_read  = req_valid && !req_we;

  secded_enc u_enc (
    .data (req_wdata),
    .word (enc_word)
  );

  secded_store #(.ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wword (wr_word),
    .raddr (rd_addr),
    .rword (rd_word),
    .iaddr (inj_addr),
    .iword (inj_word)
  );

  secded_dec u_dec (
    .word   (rd_word),
    .data   (dec_data),
    .status (dec_status),
    .fixed  (fix_word)
  );

  secded_scrub #(.ADDR_W(ADDR_W)) u_scrub (
    .clk   (clk),
    .rst_n (rst_core_n),
    .step  (scrub_go),
    .ptr   (scrub_ptr)
  );

  // single write port: request write, then injection, then scrub repair
  always_comb begin
    wr_en   = 1'b0;
    wr_addr = req_addr;
    wr_word = enc_word;
    if (rst_core_n) begin
      if (req_valid && req_we) begin
        wr_en = 1'b1;
      end else if (inj_valid) begin
        wr_en   = 1'b1;
        wr_addr = inj_addr;
        wr_word = inj_word ^ inj_mask;
      end else if (scrub_go && (dec_status == ST_FIXED)) begin
        wr_en   = 1'b1;
        wr_addr = scrub_ptr;
        wr_word = fix_word;
      end
    end
  end

  always_comb begin
    rsp_valid_d = is_read;
    rsp_data_d  = dec_data;
    rsp_stat_d  = dec_status;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_stat_q  <= ST_CLEAN;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (is_read) begin
        rsp_data_q <= rsp_data_d;
        rsp_stat_q <= rsp_stat_d;
      end
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_data_q;
  assign rsp_status = rsp_stat_q;
endmodule

// File: rtl/secded_mem_chk.sv
module secded_mem_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              req_valid,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_wdata,
  input logic              inj_valid,
  input logic              rsp_valid,
  input logic [7:0]        rsp_rdata,
  input logic [1:0]        rsp_status,
  input logic [12:0]       rd_word,
  input logic [ADDR_W-1:0] scrub_ptr
);
  p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    rsp_valid == $past(req_valid && !req_we));

  p_status_legal_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    rsp_status != 2'b11);

  p_fatal_raw_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && !req_we) |=> ((rsp_status != 2'b10) || (rsp_rdata == $past(rd_word[7:0]))));

  p_write_read_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && !req_we && $past(req_valid && req_we) && ($past(req_addr) == req_addr))
      |=> (rsp_status == 2'b00 && rsp_rdata == $past(req_wdata, 2)));

  p_scrub_hold_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid || inj_valid) |=> (scrub_ptr == $past(scrub_ptr)));

  p_scrub_step_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!req_valid && !inj_valid) |=> (scrub_ptr == ADDR_W'($past(scrub_ptr) + 1'b1)));
endmodule

bind secded_mem secded_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .req_valid  (req_valid),
  .req_we     (req_we),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .inj_valid  (inj_valid),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .rsp_status (rsp_status),
  .rd_word    (rd_word),
  .scrub_ptr  (scrub_ptr)
);

// File: tb/secded_mem_tb.sv
`timescale 1ns/1ps
module secded_mem_tb;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_we;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_wdata;
  logic          rsp_valid;
  logic [7:0]    rsp_rdata;
  logic [1:0]    rsp_status;
  logic          inj_valid;
  logic [AW-1:0] inj_addr;
  logic [12:0]   inj_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  secded_mem #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status),
    .inj_valid(inj_valid), .inj_addr(inj_addr), .inj_mask(inj_mask)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // each step drives at a falling edge and returns at the next one
  task automatic step_idle();
    req_valid = 0; req_we = 0; inj_valid = 0;
    @(negedge clk);
  endtask

  task automatic step_write(input int a, input int d);
    req_valid = 1; req_we = 1; req_addr = AW'(a); req_wdata = 8'(d); inj_valid = 0;
    @(negedge clk);
  endtask

  task automatic step_inject(input int a, input int m);
    req_valid = 0; req_we = 0; inj_valid = 1; inj_addr = AW'(a); inj_mask = 13'(m);
    @(negedge clk);
  endtask

  task automatic step_read(input int a);
    req_valid = 1; req_we = 0; req_addr = AW'(a); inj_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int clean_cnt, first_fix, second_cnt;
    rst_n = 0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    inj_valid = 0; inj_addr = '0; inj_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) step_idle();
    check("reset rsp_valid", int'(rsp_valid), 0);
    check("reset rsp_status", int'(rsp_status), 0);

    // R1 + R2: every data value round trips clean
    for (int d = 0; d < 256; d++) begin
      step_write(d % N, d);
      check("R2 no response to write", int'(rsp_valid), 0);
      step_read(d % N);
      check("R2 rsp_valid after read", int'(rsp_valid), 1);
      check("R1 clean data", int'(rsp_rdata), d);
      check("R1 clean status", int'(rsp_status), 0);
    end

    // R3/R4: every single-bit flip across several patterns
    for (int p = 0; p < 8; p++) begin
      int d;
      d = (p * 37 + 5) & 8'hFF;
      if (p == 0) d = 8'h00;
      if (p == 1) d = 8'hFF;
      for (int b = 0; b < 13; b++) begin
        step_write(b, d);
        step_inject(b, 1 << b);
        step_read(b);
        check(b < 8 ? "R3 data fixed" : "R4 data kept", int'(rsp_rdata), d);
        check(b < 8 ? "R3 status" : "R4 status", int'(rsp_status), 1);
      end
    end

    // R5: all double flips
    for (int i = 0; i < 13; i++) begin
      for (int j = i + 1; j < 13; j++) begin
        int m;
        m = (1 << i) | (1 << j);
        step_write(3, 8'h5A);
        step_inject(3, m);
        step_read(3);
        check("R5 status", int'(rsp_status), 2);
        check("R5 raw data", int'(rsp_rdata), (8'h5A ^ (m & 8'hFF)));
      end
    end

    // R6: odd parity, syndromes 13/14/15 match no column
    begin
      int masks [3];
      masks[0] = (1 << 8) | (1 << 10) | (1 << 11);
      masks[1] = (1 << 9) | (1 << 10) | (1 << 11);
      masks[2] = 13'h1F00;
      for (int k = 0; k < 3; k++) begin
        step_write(7, 8'hC3);
        step_inject(7, masks[k]);
        step_read(7);
        check("R6 status", int'(rsp_status), 2);
        check("R6 data unaltered", int'(rsp_rdata), 8'hC3);
      end
    end

    // R10: injection ignored when a write happens in the same cycle
    step_write(9, 8'h11);
    req_valid = 1; req_we = 1; req_addr = AW'(9); req_wdata = 8'h22;
    inj_valid = 1; inj_addr = AW'(9); inj_mask = 13'h0003;
    @(negedge clk);
    step_read(9);
    check("R10 write wins data", int'(rsp_rdata), 8'h22);
    check("R10 write wins status", int'(rsp_status), 0);

    // R7/R8: scrubber stalls under traffic and advances one per idle cycle
    for (int a = 0; a < N; a++) step_write(a, a * 17 + 3);
    for (int a = 0; a < N; a++) step_inject(a, 1);
    step_idle();
    clean_cnt = 0; first_fix = -1;
    for (int a = 0; a < N; a++) begin
      step_read(a);
      check("R3 fixed data during scrub", int'(rsp_rdata), (a * 17 + 3) & 8'hFF);
      if (rsp_status == 2'b00) begin clean_cnt++; first_fix = a; end
    end
    check("R8 one word scrubbed after one idle", clean_cnt, 1);
    step_idle();
    second_cnt = 0;
    for (int a = 0; a < N; a++) begin
      step_read(a);
      if (rsp_status == 2'b00) begin
        second_cnt++;
        if (a != first_fix)
          check("R7 next scrubbed location", a, (first_fix + 1) % N);
      end
    end
    check("R7 two words scrubbed", second_cnt, 2);

    // R9: double upset survives a full pass; R7: all others repaired
    step_inject(first_fix, 3);
    repeat (N + 2) step_idle();
    for (int a = 0; a < N; a++) begin
      step_read(a);
      if (a == first_fix) begin
        check("R9 status kept", int'(rsp_status), 2);
        check("R9 raw data", int'(rsp_rdata), ((a * 17 + 3) ^ 3) & 8'hFF);
      end else begin
        check("R7 repaired after pass", int'(rsp_status), 0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule